// File: doc/BRIEF.md
# Unaligned Transmit Buffer Realigner

The realigner moves one transmit buffer from a byte-addressed memory into a 32-bit transmit FIFO. It takes a buffer start byte address, a byte count and two segment flags: opens-frame and closes-frame. From these it issues word-aligned read requests to a 32-bit memory port and repacks the returned words so that each FIFO write holds four consecutive frame bytes. Bytes in the first fetched word that sit below the start address are discarded. Bytes in the final fetched word past the byte count are also discarded.

When a buffer does not close the frame, up to three bytes that do not fill a word are kept in a residue register. The next buffer of the same frame continues packing from them. When the buffer closes the frame, the last word may be partial. It is tagged end of frame and carries a valid-byte count. The first word written after an opening buffer is tagged start of frame. A one-cycle done pulse marks the end of each buffer.

All three sides use valid/ready handshakes. A stalled FIFO holds the response side, which stops further read issue once the outstanding-read limit is reached. Byte counts of zero are not supported.

Top module: `tx_realign`

## Requirements
- R1: Reads begin at the start address with its two low bits cleared and step by 4 bytes. Exactly ceil((start[1:0] + count) / 4) reads are issued per buffer, and every request address has bits [1:0] equal to zero.
- R2: Bytes of the first fetched word below the start address never reach the FIFO. The byte at the start address is the first byte forwarded and lands in the lowest free lane.
- R3: Exactly `count` bytes of each buffer are forwarded, and trailing bytes of the final fetched word are dropped. For a buffer, the number of FIFO writes equals the whole words completed from the residue plus its bytes, plus one partial word if it closes the frame with a remainder.
- R4: Every FIFO word other than an end-of-frame word carries four valid bytes, and `fifo_bcnt_o` reads 0 on it.
- R5: On the end-of-frame word, `fifo_bcnt_o` holds the number of valid bytes modulo 4, with 0 meaning all four. The valid bytes sit little-endian in the low lanes, with the lowest address in bits [7:0], and unused lanes are zero.
- R6: After a buffer flagged as opening a frame is accepted, the first FIFO write carries `fifo_sof_o`. If that buffer writes nothing, the tag moves to the first write of a later buffer. No other write carries it.
- R7: `fifo_eof_o` is set only on the final FIFO write of a buffer flagged as closing the frame.
- R8: Residue bytes left by a buffer that does not close the frame come out, in order, ahead of the next buffer's bytes. A multi-buffer frame arrives as one contiguous byte stream.
- R9: `done_o` is a one-cycle pulse in the cycle after the buffer's final handshake. That handshake is the last response accepted, or the residue flush write when one is needed.
- R10: At most MAX_OUT reads are outstanding. While the FIFO withholds ready, `fifo_valid_o` and `fifo_data_o` hold, and read issue stops at the limit.
- R11: Out of reset and while idle, `buf_ready_o` is 1 and `rd_req_valid_o`, `fifo_valid_o` and `done_o` are 0. Once a buffer is accepted, `buf_ready_o` is 0 from the next cycle until done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| buf_valid_i | input | 1 | Buffer descriptor offered |
| buf_ready_o | output | 1 | Idle, descriptor can be taken |
| buf_addr_i | input | ADDR_W | Buffer start byte address |
| buf_len_i | input | LEN_W | Buffer byte count (at least 1) |
| buf_first_i | input | 1 | Buffer opens a frame |
| buf_last_i | input | 1 | Buffer closes a frame |
| rd_req_valid_o | output | 1 | Read request valid |
| rd_req_ready_i | input | 1 | Memory accepts request |
| rd_req_addr_o | output | ADDR_W | Word-aligned read address |
| rd_rsp_valid_i | input | 1 | Read data valid, in request order |
| rd_rsp_ready_o | output | 1 | Read data accepted |
| rd_rsp_data_i | input | 32 | Read data, lowest address in bits [7:0] |
| fifo_valid_o | output | 1 | FIFO write valid |
| fifo_ready_i | input | 1 | FIFO can take a word |
| fifo_data_o | output | 32 | Packed frame bytes |
| fifo_sof_o | output | 1 | Start-of-frame tag |
| fifo_eof_o | output | 1 | End-of-frame tag |
| fifo_bcnt_o | output | 2 | Valid bytes mod 4 on end-of-frame word |
| done_o | output | 1 | Buffer finished pulse |

## Verification
A FIFO write appears in the same cycle as the read response that completes it, because the packer is combinational from response to FIFO. A residue flush word appears in the cycle after the final response is taken. `done_o` rises one cycle after the last handshake, and `buf_ready_o` falls one cycle after acceptance. The bench drives inputs on the falling edge and samples one time unit later, so it records each handshake in the cycle whose rising edge commits it. It then compares the cycle index of `done_o` against the last recorded handshake plus one. FIFO words are captured as they are accepted and checked against byte streams computed from the memory pattern once the buffer reports done.

// File: rtl/tx_realign_pkg.sv
package tx_realign_pkg;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned WORD_BYTES = 4;
  localparam int unsigned DATA_W     = BYTE_W * WORD_BYTES;
  localparam int unsigned LANE_W     = $clog2(WORD_BYTES);

  typedef logic [LANE_W-1:0] lane_t;

  typedef struct packed {
    logic  last;
    lane_t off;
    lane_t tail;
  } seg_cfg_t;

  function automatic logic [DATA_W-1:0] keep_low_bytes(logic [DATA_W-1:0] w,
                                                       logic [LANE_W:0] n);
    logic [DATA_W-1:0] r;
    r = w;
    for (int i = 0; i < int'(WORD_BYTES); i++) begin
      if ((LANE_W+1)'(i) >= n) r[i*BYTE_W +: BYTE_W] = '0;
    end
    return r;
  endfunction
endpackage

// File: rtl/tx_realign_req.sv
module tx_realign_req
  import tx_realign_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned CNT_W   = 14,
  parameter int unsigned MAX_OUT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [CNT_W-1:0]  nwords_i,
  input  logic              data_fire_i,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [ADDR_W-1:0] req_addr_o
);
  localparam int unsigned OUT_W = $clog2(MAX_OUT + 1);

  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  left_q;
  logic [OUT_W-1:0]  out_q;
  logic              req_fire;

  assign req_valid_o = (left_q != '0) && (out_q < OUT_W'(MAX_OUT));
  assign req_fire    = req_valid_o && req_ready_i;
  assign req_addr_o  = addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      left_q <= '0;
    end else if (start_i) begin
      addr_q <= base_i;
      left_q <= nwords_i;
    end else if (req_fire) begin
      addr_q <= addr_q + ADDR_W'(WORD_BYTES);
      left_q <= left_q - 1'b1;
    end
  end

  // outstanding reads: issued but not yet returned
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= '0;
    else begin
      case ({req_fire, data_fire_i})
        2'b10:   out_q <= out_q + 1'b1;
        2'b01:   out_q <= out_q - 1'b1;
        default: out_q <= out_q;
      endcase
    end
  end

  AST_OUT_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_q <= OUT_W'(MAX_OUT)); // R10
  AST_NO_STRAY_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_fire_i |-> out_q != '0); // R10
  AST_REQ_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> req_addr_o[LANE_W-1:0] == '0); // R1
  AST_REQ_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_fire && !start_i |=> req_addr_o == $past(req_addr_o) + ADDR_W'(WORD_BYTES)); // R1
endmodule

// File: rtl/tx_realign_pack.sv
module tx_realign_pack
  import tx_realign_pkg::*;
#(
  parameter int unsigned CNT_W = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  seg_cfg_t          cfg_i,
  input  logic              first_i,
  input  logic [CNT_W-1:0]  nwords_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_sof_o,
  output logic              out_eof_o,
  output lane_t             out_bcnt_o,
  output logic              fin_o
);
  localparam int unsigned RES_W = (WORD_BYTES - 1) * BYTE_W;
  localparam int unsigned CAT_W = RES_W + DATA_W;
  localparam int unsigned SUM_W = LANE_W + 1;

  seg_cfg_t         cfg_q;
  logic [CNT_W-1:0] left_q;
  logic             head_q;
  logic [RES_W-1:0] res_q;
  lane_t            rcnt_q;
  logic             sof_pend_q;
  logic             flush_q;

  lane_t             lo, hi, rest_cnt;
  logic [SUM_W-1:0]  n_in, total;
  logic [DATA_W-1:0] fresh;
  logic [CAT_W-1:0]  cat;
  logic [RES_W-1:0]  rest_res;
  logic              is_last, emit, active, need_flush, in_fire, out_fire;

  assign is_last = (left_q == CNT_W'(1));
  assign active  = (left_q != '0) && !flush_q;

  always_comb begin
    lo       = head_q  ? cfg_q.off  : '0;
    hi       = is_last ? cfg_q.tail : lane_t'(WORD_BYTES - 1);
    n_in     = SUM_W'(hi) - SUM_W'(lo) + 1'b1;
    total    = SUM_W'(rcnt_q) + n_in;
    fresh    = keep_low_bytes(in_data_i >> (BYTE_W * lo), n_in);
    cat      = ({{RES_W{1'b0}}, fresh} << (BYTE_W * rcnt_q)) | {{DATA_W{1'b0}}, res_q};
    emit     = total >= SUM_W'(WORD_BYTES);
    rest_cnt = emit ? lane_t'(total - SUM_W'(WORD_BYTES)) : lane_t'(total);
    rest_res = emit ? cat[CAT_W-1:DATA_W] : cat[RES_W-1:0];
    need_flush = is_last && cfg_q.last && (rest_cnt != '0);
  end

  always_comb begin
    out_sof_o = sof_pend_q;
    if (flush_q) begin
      out_valid_o = 1'b1;
      out_data_o  = {{BYTE_W{1'b0}}, res_q};
      out_eof_o   = 1'b1;
      out_bcnt_o  = rcnt_q;
      in_ready_o  = 1'b0;
    end else begin
      out_valid_o = active && in_valid_i && emit;
      out_data_o  = cat[DATA_W-1:0];
      out_eof_o   = is_last && cfg_q.last && (rest_cnt == '0);
      out_bcnt_o  = '0;
      in_ready_o  = active && (!emit || out_ready_i);
    end
  end

  assign in_fire  = in_valid_i && in_ready_o;
  assign out_fire = out_valid_o && out_ready_i;
  assign fin_o    = (in_fire && is_last && !need_flush) || (flush_q && out_fire);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q      <= '0;
      left_q     <= '0;
      head_q     <= 1'b0;
      res_q      <= '0;
      rcnt_q     <= '0;
      sof_pend_q <= 1'b0;
      flush_q    <= 1'b0;
    end else if (start_i) begin
      cfg_q  <= cfg_i;
      left_q <= nwords_i;
      head_q <= 1'b1;
      if (first_i) begin
        sof_pend_q <= 1'b1;
        res_q      <= '0;
        rcnt_q     <= '0;
      end
    end else begin
      if (in_fire) begin
        left_q <= left_q - 1'b1;
        head_q <= 1'b0;
        res_q  <= rest_res;
        rcnt_q <= rest_cnt;
        if (need_flush) flush_q <= 1'b1;
      end
      if (flush_q && out_fire) begin
        flush_q <= 1'b0;
        res_q   <= '0;
        rcnt_q  <= '0;
      end
      if (out_fire) sof_pend_q <= 1'b0;
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o) && $stable(out_eof_o)); // R10
  AST_RES_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_q >> (BYTE_W * rcnt_q)) == '0); // R5
  AST_SOF_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_fire && out_sof_o |=> !out_sof_o); // R6
  AST_PARTIAL_IS_EOF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && (out_bcnt_o != '0) |-> out_eof_o); // R4
endmodule

// File: rtl/tx_realign.sv
module tx_realign
  import tx_realign_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned LEN_W   = 14,
  parameter int unsigned MAX_OUT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              buf_valid_i,
  output logic              buf_ready_o,
  input  logic [ADDR_W-1:0] buf_addr_i,
  input  logic [LEN_W-1:0]  buf_len_i,
  input  logic              buf_first_i,
  input  logic              buf_last_i,
  output logic              rd_req_valid_o,
  input  logic              rd_req_ready_i,
  output logic [ADDR_W-1:0] rd_req_addr_o,
  input  logic              rd_rsp_valid_i,
  output logic              rd_rsp_ready_o,
  input  logic [DATA_W-1:0] rd_rsp_data_i,
  output logic              fifo_valid_o,
  input  logic              fifo_ready_i,
  output logic [DATA_W-1:0] fifo_data_o,
  output logic              fifo_sof_o,
  output logic              fifo_eof_o,
  output lane_t             fifo_bcnt_o,
  output logic              done_o
);
  localparam int unsigned CNT_W  = LEN_W;
  localparam int unsigned SPAN_W = LEN_W + 1;

  logic              busy_q, done_q, start, fin, data_fire;
  logic [SPAN_W-1:0] span;
  logic [CNT_W-1:0]  nwords;
  logic [ADDR_W-1:0] base;
  seg_cfg_t          cfg;

  assign buf_ready_o = !busy_q;
  assign start       = buf_valid_i && buf_ready_o;
  assign data_fire   = rd_rsp_valid_i && rd_rsp_ready_o;
  assign done_o      = done_q;

  always_comb begin
    span     = SPAN_W'(buf_addr_i[LANE_W-1:0]) + SPAN_W'(buf_len_i);
    nwords   = CNT_W'((span + SPAN_W'(WORD_BYTES - 1)) >> LANE_W);
    base     = {buf_addr_i[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
    cfg.last = buf_last_i;
    cfg.off  = buf_addr_i[LANE_W-1:0];
    cfg.tail = lane_t'(span - 1'b1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= fin;
      if (start)    busy_q <= 1'b1;
      else if (fin) busy_q <= 1'b0;
    end
  end

  tx_realign_req #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .MAX_OUT(MAX_OUT)
  ) i_req (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .base_i     (base),
    .nwords_i   (nwords),
    .data_fire_i(data_fire),
    .req_valid_o(rd_req_valid_o),
    .req_ready_i(rd_req_ready_i),
    .req_addr_o (rd_req_addr_o)
  );

  tx_realign_pack #(
    .CNT_W(CNT_W)
  ) i_pack (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .cfg_i      (cfg),
    .first_i    (buf_first_i),
    .nwords_i   (nwords),
    .in_valid_i (rd_rsp_valid_i),
    .in_ready_o (rd_rsp_ready_o),
    .in_data_i  (rd_rsp_data_i),
    .out_valid_o(fifo_valid_o),
    .out_ready_i(fifo_ready_i),
    .out_data_o (fifo_data_o),
    .out_sof_o  (fifo_sof_o),
    .out_eof_o  (fifo_eof_o),
    .out_bcnt_o (fifo_bcnt_o),
    .fin_o      (fin)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !rd_req_valid_o && !fifo_valid_o); // R11
  AST_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> !buf_ready_o); // R11
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
endmodule

// File: tb/test_tx_realign.sv
module test_tx_realign;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_OUT    = 2;
  localparam int NVEC       = 11;

  typedef struct packed {
    logic [7:0] addr;
    logic [7:0] len;
    logic       first;
    logic       last;
    logic [1:0] mode;
    logic [3:0] exp_words;
    logic [1:0] exp_bcnt;
  } vec_t;

  // addr, len, first, last, stall mode, expected FIFO words, expected end byte count
  localparam vec_t VECS [NVEC] = '{
    '{8'h32, 8'd15, 1'b1, 1'b1, 2'd0, 4'd4, 2'd3},
    '{8'h40, 8'd8,  1'b1, 1'b1, 2'd1, 4'd2, 2'd0},
    '{8'h13, 8'd1,  1'b1, 1'b1, 2'd2, 4'd1, 2'd1},
    '{8'h21, 8'd3,  1'b1, 1'b0, 2'd3, 4'd0, 2'd0},
    '{8'h56, 8'd6,  1'b0, 1'b1, 2'd1, 4'd3, 2'd1},
    '{8'h61, 8'd7,  1'b1, 1'b0, 2'd2, 4'd1, 2'd0},
    '{8'h7B, 8'd5,  1'b0, 1'b0, 2'd0, 4'd2, 2'd0},
    '{8'h8C, 8'd4,  1'b0, 1'b1, 2'd3, 4'd1, 2'd0},
    '{8'h03, 8'd20, 1'b1, 1'b1, 2'd2, 4'd5, 2'd0},
    '{8'hA2, 8'd2,  1'b1, 1'b1, 2'd1, 4'd1, 2'd2},
    '{8'hB1, 8'd30, 1'b1, 1'b1, 2'd3, 4'd8, 2'd2}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        buf_valid = 1'b0, buf_first = 1'b0, buf_last = 1'b0;
  logic [31:0] buf_addr = '0;
  logic [13:0] buf_len = '0;
  logic        buf_ready;
  logic        req_valid, req_ready = 1'b0;
  logic [31:0] req_addr;
  logic        rsp_valid = 1'b0, rsp_ready;
  logic [31:0] rsp_data = '0;
  logic        fifo_valid, fifo_ready = 1'b0, fifo_sof, fifo_eof;
  logic [31:0] fifo_data;
  logic [1:0]  fifo_bcnt;
  logic        done;

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_realign #(.ADDR_W(32), .LEN_W(14), .MAX_OUT(MAX_OUT)) i_tx_realign (
    .clk_i(clk), .rst_ni(rst_n),
    .buf_valid_i(buf_valid), .buf_ready_o(buf_ready), .buf_addr_i(buf_addr),
    .buf_len_i(buf_len), .buf_first_i(buf_first), .buf_last_i(buf_last),
    .rd_req_valid_o(req_valid), .rd_req_ready_i(req_ready), .rd_req_addr_o(req_addr),
    .rd_rsp_valid_i(rsp_valid), .rd_rsp_ready_o(rsp_ready), .rd_rsp_data_i(rsp_data),
    .fifo_valid_o(fifo_valid), .fifo_ready_i(fifo_ready), .fifo_data_o(fifo_data),
    .fifo_sof_o(fifo_sof), .fifo_eof_o(fifo_eof), .fifo_bcnt_o(fifo_bcnt),
    .done_o(done)
  );

  int checks = 0, fails = 0;
  int cyc = 0, mode = 0;
  bit hold_fifo = 1'b0, rsp_stick = 1'b0;
  logic [31:0] rq_addr [16];
  int rq_wr = 0, rq_rd = 0, rq_cnt = 0;
  int req_count = 0, addr_err = 0, ostd_err = 0;
  logic [31:0] first_req = '0;
  logic [31:0] cap_data [64];
  bit cap_sof [64], cap_eof [64];
  logic [1:0] cap_bcnt [64];
  int cap_n = 0, last_evt = 0, done_seen = 0, done_cyc = 0;
  logic [7:0] exp_frame [64];
  int exp_len = 0, frame_cap0 = 0, frame_bufs = 0;
  bit sof_exp = 1'b0;

  function automatic logic [7:0] mem_byte(logic [31:0] a);
    return 8'(a * 7 + 3);
  endfunction

  function automatic logic [31:0] mem_word(logic [31:0] a);
    logic [31:0] w;
    for (int i = 0; i < 4; i++) w[8*i +: 8] = mem_byte(a + 32'(i));
    return w;
  endfunction

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // memory and FIFO environment: drive at falling edge, record handshakes 1 unit later
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      case (mode)
        1:       begin req_ready = 1'b1;          fifo_ready = (cyc % 3) != 0; rsp_valid = (rq_cnt > 0); end
        2:       begin req_ready = (cyc % 2) == 0; fifo_ready = 1'b1;
                       rsp_valid = (rq_cnt > 0) && (rsp_stick || (cyc % 4) != 1); end
        3:       begin req_ready = (cyc % 3) != 2; fifo_ready = (cyc % 5) < 2;
                       rsp_valid = (rq_cnt > 0) && (rsp_stick || (cyc % 2) == 0); end
        default: begin req_ready = 1'b1;          fifo_ready = 1'b1;          rsp_valid = (rq_cnt > 0); end
      endcase
      if (hold_fifo) fifo_ready = 1'b0;
      rsp_data = mem_word(rq_addr[rq_rd]);
      #1;
      rsp_stick = rsp_valid && !rsp_ready;
      if (rsp_valid && rsp_ready) begin
        rq_rd = (rq_rd + 1) % 16; rq_cnt--; last_evt = cyc;
      end
      if (req_valid && req_ready) begin
        if (req_count == 0) first_req = req_addr;
        else if (req_addr != first_req + 32'(4 * req_count)) addr_err++;
        rq_addr[rq_wr] = req_addr; rq_wr = (rq_wr + 1) % 16; rq_cnt++; req_count++;
      end
      if (rq_cnt > MAX_OUT) ostd_err++;
      if (fifo_valid && fifo_ready && cap_n < 64) begin
        cap_data[cap_n] = fifo_data; cap_sof[cap_n] = fifo_sof;
        cap_eof[cap_n] = fifo_eof; cap_bcnt[cap_n] = fifo_bcnt;
        cap_n++; last_evt = cyc;
      end
      if (done) begin done_seen++; done_cyc = cyc; end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "R9", "watchdog expired", 0, 1);
    finish_run();
  end

  int cap0 = 0;

  task automatic start_buf(input logic [31:0] a, input int n, input bit f, input bit l);
    if (f) begin exp_len = 0; frame_cap0 = cap_n; frame_bufs = 0; sof_exp = 1'b1; end
    for (int i = 0; i < n; i++) begin exp_frame[exp_len] = mem_byte(a + 32'(i)); exp_len++; end
    frame_bufs++;
    req_count = 0; addr_err = 0; done_seen = 0; cap0 = cap_n;
    @(negedge clk);
    buf_valid = 1'b1; buf_addr = a; buf_len = 14'(n); buf_first = f; buf_last = l;
    #2;
    chk(buf_ready == 1'b1, "R11", "ready when idle", buf_ready, 1);
    @(negedge clk);
    buf_valid = 1'b0;
    #2;
    chk(buf_ready == 1'b0, "R11", "ready low after accept", buf_ready, 0);
  endtask

  task automatic wait_done();
    for (int t = 0; t < 3000 && done_seen == 0; t++) begin @(negedge clk); #2; end
    repeat (3) begin @(negedge clk); #2; end
  endtask

  task automatic check_buf(input logic [31:0] a, input int n, input bit l,
                           input int exp_words, input int exp_bcnt);
    int got, nw, mism, glen;
    logic [7:0] gb;
    got = cap_n - cap0;
    nw  = (int'(a[1:0]) + n + 3) / 4;
    chk(got == exp_words, "R3", "fifo words", got, exp_words);
    chk(req_count == nw, "R1", "read count", req_count, nw);
    chk(first_req == {a[31:2], 2'b00}, "R1", "first read addr", first_req, {a[31:2], 2'b00});
    chk(addr_err == 0, "R1", "read address step", addr_err, 0);
    for (int k = 0; k < got; k++) begin
      int idx = cap0 + k;
      bit e_sof = (k == 0) && sof_exp;
      bit e_eof = l && (k == got - 1);
      chk(cap_sof[idx] == e_sof, "R6", "sof tag", cap_sof[idx], e_sof);
      chk(cap_eof[idx] == e_eof, "R7", "eof tag", cap_eof[idx], e_eof);
      if (!e_eof) chk(cap_bcnt[idx] == 2'd0, "R4", "full word count", cap_bcnt[idx], 0);
      else begin
        chk(cap_bcnt[idx] == 2'(exp_bcnt), "R5", "end byte count", cap_bcnt[idx], exp_bcnt);
        if (cap_bcnt[idx] != 2'd0)
          chk((cap_data[idx] >> (8 * cap_bcnt[idx])) == 0, "R5", "unused lanes zero",
              cap_data[idx], 0);
      end
    end
    if (got > 0) sof_exp = 1'b0;
    chk(done_seen == 1, "R9", "single done pulse", done_seen, 1);
    chk(done_cyc == last_evt + 1, "R9", "done timing", done_cyc, last_evt + 1);
    if (l) begin
      mism = 0; glen = 0;
      for (int w = frame_cap0; w < cap_n; w++) begin
        int nb = (cap_eof[w] && cap_bcnt[w] != 2'd0) ? int'(cap_bcnt[w]) : 4;
        for (int b = 0; b < nb; b++) begin
          gb = cap_data[w][8*b +: 8];
          if (glen < 64 && (glen >= exp_len || gb != exp_frame[glen])) mism++;
          glen++;
        end
      end
      chk(glen == exp_len, "R3", "frame byte count", glen, exp_len);
      chk(mism == 0, "R2", "frame bytes", mism, 0);
      if (frame_bufs > 1) chk(mism == 0 && glen == exp_len, "R8", "residue carried", mism, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2;
    chk(buf_ready == 1'b1 && !req_valid && !fifo_valid && !done, "R11", "reset state",
        {buf_ready, req_valid, fifo_valid, done}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk); #2;
    chk(buf_ready == 1'b1 && !req_valid && !fifo_valid && !done, "R11", "idle after reset",
        {buf_ready, req_valid, fifo_valid, done}, 4'b1000);

    for (int v = 0; v < NVEC; v++) begin
      mode = int'(VECS[v].mode);
      start_buf({24'h0, VECS[v].addr}, int'(VECS[v].len), VECS[v].first, VECS[v].last);
      wait_done();
      check_buf({24'h0, VECS[v].addr}, int'(VECS[v].len), VECS[v].last,
                int'(VECS[v].exp_words), int'(VECS[v].exp_bcnt));
    end

    // R10: FIFO held off, aligned buffer; read issue must stop at the limit
    mode = 0; hold_fifo = 1'b1;
    start_buf(32'hC0, 32, 1'b1, 1'b1);
    repeat (20) @(negedge clk);
    #2;
    chk(req_count == MAX_OUT, "R10", "reads stop under stall", req_count, MAX_OUT);
    chk(fifo_valid && fifo_data == mem_word(32'hC0), "R10", "held word", fifo_data,
        mem_word(32'hC0));
    repeat (10) @(negedge clk);
    #2;
    chk(req_count == MAX_OUT && cap_n == cap0, "R10", "still stalled", req_count, MAX_OUT);
    chk(fifo_valid && fifo_data == mem_word(32'hC0), "R10", "word stable", fifo_data,
        mem_word(32'hC0));
    hold_fifo = 1'b0;
    wait_done();
    check_buf(32'hC0, 32, 1'b1, 8, 0);
    chk(ostd_err == 0, "R10", "outstanding limit", ostd_err, 0);
    chk(buf_ready && !req_valid && !fifo_valid && !done, "R11", "idle at end",
        {buf_ready, req_valid, fifo_valid, done}, 4'b1000);
    finish_run();
  end
endmodule